// File: doc/BRIEF.md
# Synchronous Shift-Mode Serial Engine

This block is the clocked shift-register mode of a small serial port. It connects to external shift registers through two pins. A shift-clock pin sends a burst of exactly eight pulses for each transfer. A data pin either pulls low to send transmit bits or is sampled to collect receive bits. Bytes travel least-significant bit first in both directions.

The shift clock rests high. In each bit period the clock first spends one half period low and then one half period high. Each half period lasts `max(clk_div, 1)` system clocks. Transmit data changes only when the clock falls. Receive data is captured when the clock rises.

The direction depends on the receiver-enable input:
- **Receiver enabled:** a reception starts on a rising edge seen on the data input, or when software pulses the receive-flag clear.
- **Receiver disabled:** a write to the transmit buffer starts a transmission.
- **Receiver disabled during a reception:** the reception is abandoned.

Each direction has a sticky completion flag and a one-cycle interrupt-pending pulse.

Top module: `shift_sio`

## Requirements
- R1: Outside a transfer `sclk_out` is 1. Every completed transfer produces exactly eight falling edges of `sclk_out`.
- R2: A transmitted byte goes out bit 0 first. While bit b is on the pin, `sdata_pull_low` equals the inverse of bit b. During a transfer the pin changes only on a falling edge of `sclk_out`, so an external register clocked on the rising edge collects the byte.
- R3: `sdata_pull_low` is 1 only while a transfer is in progress.
- R4: With `rx_enable` at 0, a `tx_write` pulse seen at clock edge k starts a transmission. `sclk_out` falls at edge k. Each half period lasts `max(clk_div,1)` clocks. `tx_irq_pend` is 1 after edge k+16*max(clk_div,1).
- R5: `tx_irq_pend` is a one-cycle pulse. `tx_done_flag` rises in the same cycle and stays set until a `tx_flag_clr` pulse.
- R6: With `rx_enable` at 1 and the engine idle, either a 0-to-1 change of `sdata_in` or a `rx_flag_clr` pulse starts a reception. `sdata_in` is sampled on each rising edge of `sclk_out`, and the first sample becomes bit 0 of `rx_byte`. The completion pulse comes 16*max(clk_div,1) edges after the start edge.
- R7: `rx_irq_pend` is a one-cycle pulse. It is asserted one cycle before `rx_done_flag` sets, and `rx_byte` updates together with the flag.
- R8: Dropping `rx_enable` during a reception aborts it. Busy clears and `sclk_out` returns to 1 on the next edge, and no receive flag or pulse follows. While `rx_enable` is 0, rising edges on `sdata_in` start nothing.
- R9: A `tx_write` during a transmission is held. It starts one cycle after the current transfer ends, giving a second completion pulse 16*max(clk_div,1)+1 cycles after the first.
- R10: A `tx_write` while `rx_enable` is 1 and the engine is idle has no effect: no busy, no clock pulses, no transmit flag.
- R11: After synchronous reset `sclk_out`=1, `sdata_pull_low`=0, `busy`=0, and both flags and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | 15 | Half-period length of the shift clock in system clocks (0 acts as 1) |
| rx_enable | input | 1 | Receiver enable: 1 selects receive, 0 selects transmit |
| tx_write | input | 1 | Transmit-buffer write strobe |
| tx_byte | input | 8 | Byte to transmit |
| rx_flag_clr | input | 1 | Clears the receive flag; also starts a reception when enabled |
| tx_flag_clr | input | 1 | Clears the transmit flag |
| sdata_in | input | 1 | Data pin as seen by the input buffer |
| sclk_out | output | 1 | Shift clock pin, idles high |
| sdata_pull_low | output | 1 | Data pin driver: 1 pulls the pin low |
| rx_byte | output | 8 | Last received byte |
| tx_done_flag | output | 1 | Transmit-complete flag |
| rx_done_flag | output | 1 | Receive-complete flag |
| tx_irq_pend | output | 1 | One-cycle transmit interrupt-pending pulse |
| rx_irq_pend | output | 1 | One-cycle receive interrupt-pending pulse |
| busy | output | 1 | A transfer is in progress |

## Verification
The properties rely on the following input assumptions:
- `sdata_in` is already synchronous to `clk`.
- `rx_enable` is not raised while a transmission is running.
- At most one transmit write waits at a time.
- `clk_div` holds still during a transfer.

The bench respects these assumptions. It changes `rx_enable` and `clk_div` only while the engine is idle, except when it drops `rx_enable` on purpose to abort a reception. It issues a second write only once a transmission is under way. Its external shift-register model changes `sdata_in` only on a falling edge of the shift clock.

// File: rtl/shift_sio_pkg.sv
`timescale 1ns/1ps
package shift_sio_pkg;
  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_TX   = 2'd1,
    XF_RX   = 2'd2
  } xfer_e;
endpackage

// File: rtl/shift_sio_baud.sv
`timescale 1ns/1ps
// Half-period timer: tick marks the last system clock of a shift-clock phase.
module shift_sio_baud #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last_cnt;

  // A divisor of zero behaves like one: every clock ends a phase.
  always_comb last_cnt = (div == '0) ? '0 : div - 1'b1;

  assign tick = run && (cnt >= last_cnt);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/shift_sio_shreg.sv
`timescale 1ns/1ps
// Shared shift register: loads a transmit byte, shifts right on output,
// and shifts received bits in from the top so the first bit lands in bit 0.
module shift_sio_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift_in,
  input  logic              in_bit,
  input  logic              shift_out,
  output logic [DATA_W-1:0] sr
);
  always_ff @(posedge clk) begin
    if (rst)            sr <= '0;
    else if (load)      sr <= load_val;
    else if (shift_in)  sr <= {in_bit, sr[DATA_W-1:1]};
    else if (shift_out) sr <= {1'b0, sr[DATA_W-1:1]};
  end
endmodule

// File: rtl/shift_sio.sv
`timescale 1ns/1ps
module shift_sio
  import shift_sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              rx_enable,
  input  logic              tx_write,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              rx_flag_clr,
  input  logic              tx_flag_clr,
  input  logic              sdata_in,
  output logic              sclk_out,
  output logic              sdata_pull_low,
  output logic [DATA_W-1:0] rx_byte,
  output logic              tx_done_flag,
  output logic              rx_done_flag,
  output logic              tx_irq_pend,
  output logic              rx_irq_pend,
  output logic              busy
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  xfer_e             st;
  logic              phase_hi;
  logic [IDX_W-1:0]  bit_idx;
  logic              tick;
  logic              hold_vld;
  logic [DATA_W-1:0] hold_byte;
  logic              sd_prev;
  logic              rx_fin_d;
  logic [DATA_W-1:0] sr;

  logic              start_tx, start_rx, abort_rx, last_bit;
  logic              shift_in, shift_out;
  logic [DATA_W-1:0] start_byte;

  assign busy       = (st != XF_IDLE);
  assign start_byte = hold_vld ? hold_byte : tx_byte;
  assign start_tx   = (st == XF_IDLE) && !rx_enable && (hold_vld || tx_write);
  assign start_rx   = (st == XF_IDLE) && rx_enable &&
                      ((sdata_in && !sd_prev) || rx_flag_clr);
  assign abort_rx   = (st == XF_RX) && !rx_enable;
  assign last_bit   = (bit_idx == LAST_IDX);
  assign shift_in   = (st == XF_RX) && !abort_rx && tick && !phase_hi;
  assign shift_out  = (st == XF_TX) && tick && phase_hi && !last_bit;

  shift_sio_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (clk_div),
    .tick (tick)
  );

  shift_sio_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk       (clk),
    .rst       (rst),
    .load      (start_tx),
    .load_val  (start_byte),
    .shift_in  (shift_in),
    .in_bit    (sdata_in),
    .shift_out (shift_out),
    .sr        (sr)
  );

  // Single-entry holding slot for a write that arrives mid-transfer.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld  <= 1'b0;
      hold_byte <= '0;
    end else if (start_tx && hold_vld) begin
      hold_vld <= tx_write;
      if (tx_write) hold_byte <= tx_byte;
    end else if (tx_write && !rx_enable && busy) begin
      hold_vld  <= 1'b1;
      hold_byte <= tx_byte;
    end
  end

  // Transfer sequencer: low phase, high phase, per bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= XF_IDLE;
      sclk_out       <= 1'b1;
      sdata_pull_low <= 1'b0;
      phase_hi       <= 1'b0;
      bit_idx        <= '0;
      tx_irq_pend    <= 1'b0;
      rx_irq_pend    <= 1'b0;
      rx_fin_d       <= 1'b0;
      sd_prev        <= 1'b1;
    end else begin
      tx_irq_pend <= 1'b0;
      rx_irq_pend <= 1'b0;
      rx_fin_d    <= 1'b0;
      sd_prev     <= sdata_in;
      if (abort_rx) begin
        st       <= XF_IDLE;
        sclk_out <= 1'b1;
        phase_hi <= 1'b0;
      end else if (start_tx) begin
        st             <= XF_TX;
        sclk_out       <= 1'b0;
        sdata_pull_low <= ~start_byte[0];
        phase_hi       <= 1'b0;
        bit_idx        <= '0;
      end else if (start_rx) begin
        st       <= XF_RX;
        sclk_out <= 1'b0;
        phase_hi <= 1'b0;
        bit_idx  <= '0;
      end else if (busy && tick) begin
        if (!phase_hi) begin
          sclk_out <= 1'b1;
          phase_hi <= 1'b1;
        end else if (last_bit) begin
          st             <= XF_IDLE;
          sdata_pull_low <= 1'b0;
          phase_hi       <= 1'b0;
          if (st == XF_TX) tx_irq_pend <= 1'b1;
          else begin
            rx_irq_pend <= 1'b1;
            rx_fin_d    <= 1'b1;
          end
        end else begin
          bit_idx  <= bit_idx + 1'b1;
          sclk_out <= 1'b0;
          phase_hi <= 1'b0;
          if (st == XF_TX) sdata_pull_low <= ~sr[1];
        end
      end
    end
  end

  // Completion flags: a set in the same cycle wins over a clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done_flag <= 1'b0;
      rx_done_flag <= 1'b0;
      rx_byte      <= '0;
    end else begin
      if (st == XF_TX && tick && phase_hi && last_bit) tx_done_flag <= 1'b1;
      else if (tx_flag_clr)                            tx_done_flag <= 1'b0;
      if (rx_fin_d) begin
        rx_done_flag <= 1'b1;
        rx_byte      <= sr;
      end else if (rx_flag_clr) begin
        rx_done_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shift_sio_chk.sv
`timescale 1ns/1ps
module shift_sio_chk #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rst,
  input logic rx_enable,
  input logic sclk_out,
  input logic sdata_pull_low,
  input logic busy,
  input logic tx_irq_pend,
  input logic tx_done_flag,
  input logic rx_irq_pend,
  input logic rx_done_flag
);
  localparam int CW = $clog2(DATA_W) + 2;
  logic [CW-1:0] fall_cnt;
  logic          sclk_q, busy_q;

  // Falling edges of the shift clock since the current transfer began.
  always_ff @(posedge clk) begin
    if (rst) begin
      fall_cnt <= '0;
      sclk_q   <= 1'b1;
      busy_q   <= 1'b0;
    end else begin
      sclk_q   <= sclk_out;
      busy_q   <= busy;
      fall_cnt <= (busy_q ? fall_cnt : '0) + CW'(sclk_q && !sclk_out);
    end
  end

  assert_idle_clk_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk_out);

  assert_eight_pulses_R1: assert property (@(posedge clk) disable iff (rst)
    (tx_irq_pend || rx_irq_pend) |-> fall_cnt == CW'(DATA_W));

  assert_pin_moves_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(sdata_pull_low)) |-> $fell(sclk_out));

  assert_pull_in_transfer_R3: assert property (@(posedge clk) disable iff (rst)
    sdata_pull_low |-> busy);

  assert_tx_pend_with_flag_R5: assert property (@(posedge clk) disable iff (rst)
    tx_irq_pend |-> tx_done_flag);

  assert_tx_pend_single_R5: assert property (@(posedge clk) disable iff (rst)
    tx_irq_pend |=> !tx_irq_pend);

  assert_rx_flag_follows_R7: assert property (@(posedge clk) disable iff (rst)
    rx_irq_pend |=> (rx_done_flag && !rx_irq_pend));

  assert_rx_done_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
    rx_irq_pend |-> $past(rx_enable));
endmodule

bind shift_sio shift_sio_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .rx_enable      (rx_enable),
  .sclk_out       (sclk_out),
  .sdata_pull_low (sdata_pull_low),
  .busy           (busy),
  .tx_irq_pend    (tx_irq_pend),
  .tx_done_flag   (tx_done_flag),
  .rx_irq_pend    (rx_irq_pend),
  .rx_done_flag   (rx_done_flag)
);

// File: tb/tb_shift_sio.sv
`timescale 1ns/1ps
module tb_shift_sio;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] clk_div = '0;
  logic        rx_enable = 1'b0;
  logic        tx_write = 1'b0;
  logic [7:0]  tx_byte = '0;
  logic        rx_flag_clr = 1'b0;
  logic        tx_flag_clr = 1'b0;
  logic        sdata_in;
  logic        sclk_out, sdata_pull_low, tx_done_flag, rx_done_flag;
  logic        tx_irq_pend, rx_irq_pend, busy;
  logic [7:0]  rx_byte;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // External device models.
  logic        man_bit = 1'b0;
  logic        model_bit = 1'b0;
  bit          rx_model = 0;
  logic [7:0]  src = '0;
  int          sidx = 0;
  int          falls = 0;
  bit          cap_en = 0;
  int          cap_n = 0;
  logic [15:0] cap_word = '0;

  assign sdata_in = rx_model ? model_bit : man_bit;

  always #2 clk = ~clk;

  shift_sio dut (
    .clk(clk), .rst(rst), .clk_div(clk_div), .rx_enable(rx_enable),
    .tx_write(tx_write), .tx_byte(tx_byte), .rx_flag_clr(rx_flag_clr),
    .tx_flag_clr(tx_flag_clr), .sdata_in(sdata_in), .sclk_out(sclk_out),
    .sdata_pull_low(sdata_pull_low), .rx_byte(rx_byte),
    .tx_done_flag(tx_done_flag), .rx_done_flag(rx_done_flag),
    .tx_irq_pend(tx_irq_pend), .rx_irq_pend(rx_irq_pend), .busy(busy)
  );

  always @(negedge sclk_out) begin
    falls++;
    if (rx_model && sidx < 8) begin
      model_bit <= src[sidx];
      sidx++;
    end
  end

  always @(posedge sclk_out) begin
    if (cap_en) begin
      cap_word = {~sdata_pull_low, cap_word[15:1]};
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int half(input int dv);
    return (dv == 0) ? 1 : dv;
  endfunction

  task automatic wait_pend(input bit is_tx, output int n);
    n = 1;
    while (!(is_tx ? tx_irq_pend : rx_irq_pend) && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_tx(input logic [7:0] d, input int dv);
    int n, f0;
    @(negedge clk);
    clk_div = 15'(dv);
    cap_en = 1; cap_n = 0; f0 = falls;
    tx_byte = d; tx_write = 1;
    @(negedge clk);
    tx_write = 0;
    wait_pend(1, n);
    chk(n == 16*half(dv)+1, "R4 tx latency", n, 16*half(dv)+1);
    chk(tx_done_flag == 1, "R5 tx flag with pend", tx_done_flag, 1);
    chk(cap_word[15:8] == d, "R2 tx byte lsb first", cap_word[15:8], d);
    chk(falls - f0 == 8 && cap_n == 8, "R1 eight pulses tx", falls - f0, 8);
    @(negedge clk);
    chk(tx_irq_pend == 0 && tx_done_flag == 1, "R5 pend one cycle, flag sticky",
        {tx_irq_pend, tx_done_flag}, 1);
    chk(sdata_pull_low == 0 && sclk_out == 1, "R3 pin released, R1 clk idle high",
        {sdata_pull_low, sclk_out}, 1);
    tx_flag_clr = 1;
    @(negedge clk);
    tx_flag_clr = 0;
    chk(tx_done_flag == 0, "R5 tx flag clear", tx_done_flag, 0);
    cap_en = 0;
  endtask

  task automatic do_rx(input logic [7:0] d, input int dv, input bit use_edge);
    int n, f0;
    @(negedge clk);
    clk_div = 15'(dv);
    if (use_edge) begin
      rx_enable = 0; rx_flag_clr = 1;
      @(negedge clk);
      rx_flag_clr = 0; rx_enable = 1; man_bit = 0; rx_model = 0;
      @(negedge clk);
    end
    src = d; sidx = 0; f0 = falls;
    if (use_edge) begin
      model_bit = 1; rx_model = 1;
    end else begin
      model_bit = sdata_in; rx_model = 1; rx_flag_clr = 1;
    end
    @(negedge clk);
    rx_flag_clr = 0;
    wait_pend(0, n);
    chk(n == 16*half(dv)+1, use_edge ? "R6 rx latency edge start" : "R6 rx latency clear start",
        n, 16*half(dv)+1);
    chk(rx_done_flag == 0, "R7 pend before flag", rx_done_flag, 0);
    @(negedge clk);
    chk(rx_done_flag == 1 && rx_irq_pend == 0, "R7 flag one cycle after pend",
        {rx_done_flag, rx_irq_pend}, 2);
    chk(rx_byte == d, "R6 rx byte lsb first", rx_byte, d);
    chk(falls - f0 == 8, "R1 eight pulses rx", falls - f0, 8);
    man_bit = model_bit; rx_model = 0;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(sclk_out == 1 && sdata_pull_low == 0 && busy == 0, "R11 reset pins",
        {sclk_out, sdata_pull_low, busy}, 4);
    chk(!tx_done_flag && !rx_done_flag && !tx_irq_pend && !rx_irq_pend, "R11 reset flags",
        {tx_done_flag, rx_done_flag, tx_irq_pend, rx_irq_pend}, 0);

    // Directed transmit corners: divisor zero, one, larger
    do_tx(8'hA5, 0);
    do_tx(8'h01, 1);
    do_tx(8'h80, 3);
    do_tx(8'h00, 2);
    do_tx(8'hFF, 1);

    // R9 write during a transfer is held
    begin
      int pends, gap, last_t, t;
      int f0;
      @(negedge clk);
      clk_div = 15'd1; cap_en = 1; cap_n = 0; f0 = falls;
      tx_byte = 8'h3C; tx_write = 1;
      @(negedge clk);
      tx_write = 0;
      repeat (4) @(negedge clk);
      tx_byte = 8'hC5; tx_write = 1;
      @(negedge clk);
      tx_write = 0;
      pends = 0; gap = 0; last_t = 0;
      for (t = 0; t < 80; t++) begin
        @(negedge clk);
        if (tx_irq_pend) begin
          if (pends == 1) gap = t - last_t;
          last_t = t; pends++;
        end
      end
      chk(pends == 2, "R9 two completions", pends, 2);
      chk(gap == 17, "R9 held start spacing", gap, 17);
      chk(cap_word == 16'hC53C, "R9 held byte order", cap_word, 16'hC53C);
      chk(falls - f0 == 16, "R9 sixteen pulses", falls - f0, 16);
      cap_en = 0;
      tx_flag_clr = 1;
      @(negedge clk);
      tx_flag_clr = 0;
    end

    // R10 write ignored while receiver enabled
    begin
      int f0;
      bit seen_busy;
      @(negedge clk);
      rx_enable = 1;
      @(negedge clk);
      f0 = falls; seen_busy = 0;
      tx_byte = 8'h55; tx_write = 1;
      @(negedge clk);
      tx_write = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (busy) seen_busy = 1;
      end
      chk(!seen_busy && falls == f0 && !tx_done_flag, "R10 tx write ignored",
          {seen_busy, tx_done_flag}, 0);
    end

    // Receive: both start conditions
    do_rx(8'h96, 2, 0);
    do_rx(8'h6B, 1, 1);
    do_rx(8'h01, 0, 0);

    // R8 abort and inhibit
    begin
      int f0;
      bit seen;
      @(negedge clk);
      clk_div = 15'd2; src = 8'hF0; sidx = 0;
      model_bit = sdata_in; rx_model = 1; rx_flag_clr = 1;
      @(negedge clk);
      rx_flag_clr = 0;
      repeat (10) @(negedge clk);
      rx_enable = 0;
      @(negedge clk);
      chk(busy == 0 && sclk_out == 1, "R8 abort stops clock", {busy, sclk_out}, 1);
      man_bit = model_bit; rx_model = 0;
      seen = 0; f0 = falls;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (rx_irq_pend || busy) seen = 1;
        if (i == 10) man_bit = 0;
        if (i == 20) man_bit = 1;
      end
      chk(!seen && !rx_done_flag && falls == f0, "R8 no completion, no restart",
          {seen, rx_done_flag}, 0);
    end

    // Constrained random mix
    for (int k = 0; k < 24; k++) begin
      logic [7:0] d;
      int dv;
      d = 8'($urandom);
      dv = $urandom % 5;
      if (k % 2 == 0) begin
        @(negedge clk);
        rx_enable = 0;
        do_tx(d, dv);
      end else begin
        @(negedge clk);
        rx_enable = 1;
        @(negedge clk);
        do_rx(d, dv, ($urandom % 2) == 1);
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule